// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block takes a wide bank of level-sensitive interrupt inputs and folds them into one line per group of eight. A group line is high while at least one of its sources is both asserted and enabled. Software controls the per-source enables and reads source status through a 32-bit register port. The port has an address, write data, separate write and read strobes, registered read data and a one-cycle error flag.

Each 32-bit register word covers four adjacent groups, one byte per group. Enables change only through two write-only words. One word sets the bits written as ones. The other clears the bits written as ones. Two read-only words report raw source levels and levels after the enables. Above the group area, two summary words give one bit per group line. A build parameter selects a reduced variant that accepts inputs only for the first 16 groups.

Top module: `irq_group_combiner`

## Requirements
- R1: Input n belongs to group n/8, at bit position n mod 8 of that group. With the default of 64 groups there are 512 inputs.
- R2: Group line g is high exactly when the AND of its 8-bit enable mask and its 8-bit source level vector is nonzero. It is registered: it changes on the first clock edge after an input change or an enable write, and not before.
- R3: A source's status bit follows its input level with no latching. When the input goes low, the group line falls unless another enabled source of the group is still high.
- R4: Byte address bits [7:4] pick quad q, which is groups 4q to 4q+3. Bits [3:2] pick the word: 0 = enable set, 1 = enable clear, 2 = raw status, 3 = masked status. Byte lane k (bits 8k+7..8k) belongs to group 4q+k. Address bits [1:0] are ignored.
- R5: A write to word 0 ORs each byte into that group's enable mask. Zero bits leave the mask unchanged.
- R6: A write to word 1 clears the enable bits written as ones. Zero bits leave the mask unchanged.
- R7: Reading word 2 returns the source levels of the four groups. Reading word 3 returns levels AND enables. Read data appears on the clock edge after the read strobe.
- R8: Byte address 0x100 reads group lines 0..31 in bits 0..31. Address 0x104 reads group lines 32..63.
- R9: A write to word 2 or word 3, or to any address at or above 0x100, changes no enable and pulses the error flag for one cycle after the strobe. Accepted writes leave the flag low.
- R10: Reads of words 0 and 1 return zero. A read at or above 0x108 returns zero and pulses the error flag. Reads inside the window leave the flag low.
- R11: In the reduced variant, inputs of groups 16 and above are ignored. Their status reads zero and their lines stay low whatever the enables are.
- R12: Reset clears every enable mask and status vector, so all group lines and both summary words read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; inputs are synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 512 | Level interrupt sources, input n in group n/8 |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| reg_err | output | 1 | One-cycle pulse after a rejected access |
| grp_irq_out | output | 64 | One registered line per group |

## Verification
The hardest behaviour to observe is the reduced variant. Its ignored groups must stay silent while receiving the same enables and the same input activity as an active group. The bench therefore drives one register bus and one input vector into a full instance and a reduced instance side by side. It compares their lines, raw status and summary words for the same group. Rejected writes are also hard to see, because a misdecoded status-word write would act as a clear. So each rejected write carries ones, and the bench then reads the masked status, which must be unchanged. The registered latency is probed between the input change and the next edge, where the line must still be low.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int GRP_W  = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = GRP_W * LANES;

  typedef enum logic [1:0] {
    QREG_EN_SET = 2'd0,
    QREG_EN_CLR = 2'd1,
    QREG_RAW    = 2'd2,
    QREG_MASKED = 2'd3
  } qreg_e;

  // group line rule: any enabled source high
  function automatic logic grp_fire(input logic [GRP_W-1:0] en,
                                    input logic [GRP_W-1:0] lvl);
    return |(en & lvl);
  endfunction

  // next enable mask after a set or clear write
  function automatic logic [GRP_W-1:0] en_update(input logic [GRP_W-1:0] cur,
                                                 input logic do_set,
                                                 input logic do_clr,
                                                 input logic [GRP_W-1:0] bits);
    logic [GRP_W-1:0] r;
    r = cur;
    if (do_set)      r = cur | bits;
    else if (do_clr) r = cur & ~bits;
    return r;
  endfunction
endpackage

// File: rtl/irqc_group_cell.sv
module irqc_group_cell
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] src,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic [GRP_W-1:0] wbits,
  output logic [GRP_W-1:0] pend_q,
  output logic [GRP_W-1:0] mask_q,
  output logic             fire_q
);
  logic [GRP_W-1:0] mask_nxt;

  always_comb mask_nxt = en_update(mask_q, set_stb, clr_stb, wbits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      fire_q <= 1'b0;
    end else begin
      pend_q <= src;
      mask_q <= mask_nxt;
      fire_q <= grp_fire(mask_nxt, src);
    end
  end

  // R2: registered line agrees with the registered mask and levels
  a_r2_line_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q == (|(mask_q & pend_q)));

  // R5: a set write keeps old bits and adds the written ones
  a_r5_set_adds: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((mask_q & $past(mask_q)) == $past(mask_q)) &&
                ((mask_q & $past(wbits)) == $past(wbits)));

  // R6: a clear write drops written ones and keeps the rest
  a_r6_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((mask_q & $past(wbits)) == '0) &&
                ((mask_q & ~$past(wbits)) == ($past(mask_q) & ~$past(wbits))));

  // R9: without a strobe the mask holds
  a_r9_mask_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(mask_q));
endmodule

// File: rtl/irqc_addr_decode.sv
module irqc_addr_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_GROUPS = 64
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [$clog2(NUM_GROUPS/LANES)-1:0] quad_idx,
  output qreg_e             qreg,
  output logic              grp_area,
  output logic              sum_hit,
  output logic [((NUM_GROUPS/WORD_W) > 1 ? $clog2(NUM_GROUPS/WORD_W) : 1)-1:0] sum_idx,
  output logic              set_stb,
  output logic              clr_stb,
  output logic              wr_reject,
  output logic              rd_reject
);
  localparam int QW        = $clog2(NUM_GROUPS/LANES);
  localparam int SUM_WORDS = NUM_GROUPS / WORD_W;
  localparam int SW        = (SUM_WORDS > 1) ? $clog2(SUM_WORDS) : 1;
  localparam int SUM_BASE  = NUM_GROUPS * LANES;
  localparam int WIN_END   = SUM_BASE + SUM_WORDS * LANES;

  logic [ADDR_W-1:0] sum_off;
  logic              unused_bits;
  logic              wr_ok;

  always_comb begin
    grp_area  = reg_addr < ADDR_W'(SUM_BASE);
    sum_hit   = !grp_area && (reg_addr < ADDR_W'(WIN_END));
    quad_idx  = reg_addr[QW+3:4];
    qreg      = qreg_e'(reg_addr[3:2]);
    sum_off   = reg_addr - ADDR_W'(SUM_BASE);
    sum_idx   = sum_off[SW+1:2];
    wr_ok     = grp_area && (qreg == QREG_EN_SET || qreg == QREG_EN_CLR);
    set_stb   = reg_wr && wr_ok && (qreg == QREG_EN_SET);
    clr_stb   = reg_wr && wr_ok && (qreg == QREG_EN_CLR);
    wr_reject = reg_wr && !wr_ok;
    rd_reject = reg_rd && !grp_area && !sum_hit;
  end

  assign unused_bits = ^{reg_addr[1:0], sum_off};
endmodule

// File: rtl/irqc_read_mux.sv
module irqc_read_mux
  import irqc_pkg::*;
#(
  parameter int NUM_GROUPS = 64
) (
  input  logic [NUM_GROUPS*GRP_W-1:0] pend_flat,
  input  logic [NUM_GROUPS*GRP_W-1:0] mask_flat,
  input  logic [NUM_GROUPS-1:0]       fire,
  input  logic [$clog2(NUM_GROUPS/LANES)-1:0] quad_idx,
  input  qreg_e                       qreg,
  input  logic                        grp_area,
  input  logic                        sum_hit,
  input  logic [((NUM_GROUPS/WORD_W) > 1 ? $clog2(NUM_GROUPS/WORD_W) : 1)-1:0] sum_idx,
  output logic [WORD_W-1:0]           rdata
);
  localparam int SUM_W = ((NUM_GROUPS + WORD_W - 1) / WORD_W) * WORD_W;

  logic [SUM_W-1:0]  fire_pad;
  logic [WORD_W-1:0] raw_word;
  logic [WORD_W-1:0] en_word;

  always_comb begin
    fire_pad = SUM_W'(fire);
    raw_word = pend_flat[quad_idx*WORD_W +: WORD_W];
    en_word  = mask_flat[quad_idx*WORD_W +: WORD_W];
    rdata    = '0;
    if (grp_area) begin
      case (qreg)
        QREG_RAW:    rdata = raw_word;
        QREG_MASKED: rdata = raw_word & en_word;
        default:     rdata = '0;
      endcase
    end else if (sum_hit) begin
      rdata = fire_pad[sum_idx*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
  import irqc_pkg::*;
#(
  parameter int NUM_GROUPS = 64,
  parameter bit EXT_MODE   = 1'b0,
  parameter int EXT_GROUPS = 16,
  parameter int ADDR_W     = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_GROUPS*8-1:0]     irq_in,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [31:0]                 reg_wdata,
  input  logic                        reg_wr,
  input  logic                        reg_rd,
  output logic [31:0]                 reg_rdata,
  output logic                        reg_err,
  output logic [NUM_GROUPS-1:0]       grp_irq_out
);
  localparam int QW        = $clog2(NUM_GROUPS/LANES);
  localparam int SUM_WORDS = NUM_GROUPS / WORD_W;
  localparam int SW        = (SUM_WORDS > 1) ? $clog2(SUM_WORDS) : 1;
  localparam int SUM_BASE  = NUM_GROUPS * LANES;
  localparam int WIN_END   = SUM_BASE + SUM_WORDS * LANES;

  logic [QW-1:0]   quad_idx;
  qreg_e           qreg;
  logic            grp_area, sum_hit, set_stb, clr_stb, wr_reject, rd_reject;
  logic [SW-1:0]   sum_idx;
  logic [NUM_GROUPS*GRP_W-1:0] pend_flat, mask_flat;
  logic [WORD_W-1:0] rd_word;

  irqc_addr_decode #(.ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS)) u_dec (
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .quad_idx (quad_idx),
    .qreg     (qreg),
    .grp_area (grp_area),
    .sum_hit  (sum_hit),
    .sum_idx  (sum_idx),
    .set_stb  (set_stb),
    .clr_stb  (clr_stb),
    .wr_reject(wr_reject),
    .rd_reject(rd_reject)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam bit ACCEPT = !EXT_MODE || (g < EXT_GROUPS);
    logic [GRP_W-1:0] src_g;
    logic             hit_g;

    if (ACCEPT) begin : g_live
      assign src_g = irq_in[g*GRP_W +: GRP_W];
    end else begin : g_dead
      assign src_g = '0;
    end

    assign hit_g = (quad_idx == QW'(g / LANES));

    irqc_group_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (src_g),
      .set_stb(set_stb && hit_g),
      .clr_stb(clr_stb && hit_g),
      .wbits  (reg_wdata[(g % LANES)*GRP_W +: GRP_W]),
      .pend_q (pend_flat[g*GRP_W +: GRP_W]),
      .mask_q (mask_flat[g*GRP_W +: GRP_W]),
      .fire_q (grp_irq_out[g])
    );

    if (!ACCEPT) begin : g_quiet
      // R11: ignored groups never raise their line
      a_r11_ignored_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_irq_out[g]);
    end
  end

  irqc_read_mux #(.NUM_GROUPS(NUM_GROUPS)) u_rmux (
    .pend_flat(pend_flat),
    .mask_flat(mask_flat),
    .fire     (grp_irq_out),
    .quad_idx (quad_idx),
    .qreg     (qreg),
    .grp_area (grp_area),
    .sum_hit  (sum_hit),
    .sum_idx  (sum_idx),
    .rdata    (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      reg_err   <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_word;
      reg_err <= wr_reject || rd_reject;
    end
  end

  // R9: writes to status words or the summary area flag an error
  a_r9_bad_write_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr >= ADDR_W'(SUM_BASE) || reg_addr[3])) |=> reg_err);

  // R9: such writes leave every enable untouched
  a_r9_bad_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr >= ADDR_W'(SUM_BASE) || reg_addr[3])) |=> $stable(mask_flat));

  // R10: reads past the window return zero with an error
  a_r10_far_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr >= ADDR_W'(WIN_END)) |=> (reg_err && reg_rdata == '0));

  // R10: reads inside the window raise no error
  a_r10_near_read_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr < ADDR_W'(WIN_END)) |=> !reg_err);
endmodule

// File: tb/irq_group_combiner_tb_top.sv
module irq_group_combiner_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [511:0] irq_in = '0;
  logic [11:0]  reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic         reg_wr = 1'b0;
  logic         reg_rd = 1'b0;
  logic [31:0]  rdata_m, rdata_x;
  logic         err_m, err_x;
  logic [63:0]  out_m;
  logic [15:0]  out_x_lo;
  logic [47:0]  out_x_hi;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] rd_m, rd_x;
  logic        rerr_m, rerr_x;

  always #10 clk = ~clk;

  irq_group_combiner dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(rdata_m), .reg_err(err_m), .grp_irq_out(out_m)
  );

  irq_group_combiner #(.EXT_MODE(1'b1)) dut_ext_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(rdata_x), .reg_err(err_x), .grp_irq_out({out_x_hi, out_x_lo})
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    rd_m = rdata_m; rd_x = rdata_x; rerr_m = err_m; rerr_x = err_x;
  endtask

  task automatic set_irq(input int n, input logic v);
    @(negedge clk);
    irq_in[n] = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R12 lines after reset", out_m, 64'h0);
    rd(12'h100); chk("R12 summary low", rd_m, 0);
    rd(12'h104); chk("R12 summary high", rd_m, 0);
  endtask

  task automatic t_mapping;
    wr(12'h010, 32'h0000_FF00);
    @(negedge clk);
    irq_in[43] = 1'b1;
    #1 chk("R2 no change before edge", out_m, 64'h0);
    @(negedge clk);
    chk("R1 input 43 drives group 5", out_m, 64'h20);
    rd(12'h018); chk("R4 raw lane1 bit3", rd_m, 32'h0000_0800);
    rd(12'h01C); chk("R7 masked status", rd_m, 32'h0000_0800);
    set_irq(32, 1'b1);
    chk("R2 disabled source stays out", out_m, 64'h20);
    rd(12'h018); chk("R7 raw shows disabled source", rd_m, 32'h0000_0801);
    rd(12'h01C); chk("R7 masked hides disabled source", rd_m, 32'h0000_0800);
    set_irq(43, 1'b0);
    chk("R3 line follows input low", out_m, 64'h0);
    set_irq(32, 1'b0);
  endtask

  task automatic t_setclr;
    @(negedge clk); irq_in[3:0] = 4'hF;
    wr(12'h000, 32'h1); rd(12'h00C); chk("R5 first set", rd_m, 32'h1);
    wr(12'h000, 32'h2); rd(12'h00C); chk("R5 set keeps old bits", rd_m, 32'h3);
    wr(12'h004, 32'h1); rd(12'h00C); chk("R6 clear one bit", rd_m, 32'h2);
    chk("R6 line still high", out_m, 64'h1);
    wr(12'h004, 32'h2); rd(12'h00C); chk("R6 clear last bit", rd_m, 32'h0);
    chk("R6 line falls", out_m, 64'h0);
  endtask

  task automatic t_reject;
    wr(12'h000, 32'hF);
    chk("R9 accepted write no error", err_m, 0);
    wr(12'h00C, 32'hFFFF_FFFF); chk("R9 masked word write flagged", err_m, 1);
    wr(12'h008, 32'hFFFF_FFFF); chk("R9 raw word write flagged", err_m, 1);
    wr(12'h100, 32'hFFFF_FFFF); chk("R9 summary write flagged", err_m, 1);
    rd(12'h00C); chk("R9 enables unchanged", rd_m, 32'hF);
  endtask

  task automatic t_reads;
    rd(12'h000); chk("R10 set word reads zero", rd_m, 0); chk("R10 no error", rerr_m, 0);
    rd(12'h004); chk("R10 clear word reads zero", rd_m, 0);
    rd(12'h100); chk("R8 summary group0", rd_m, 32'h1);
    rd(12'h108); chk("R10 beyond window zero", rd_m, 0); chk("R10 beyond window error", rerr_m, 1);
    rd(12'hFFC); chk("R10 far read error", rerr_m, 1);
    wr(12'h004, 32'hF);
    @(negedge clk); irq_in[3:0] = 4'h0;
  endtask

  task automatic t_summary;
    wr(12'h0A0, 32'h0000_0001);
    wr(12'h0F0, 32'h0100_0000);
    @(negedge clk); irq_in[320] = 1'b1; irq_in[504] = 1'b1;
    @(negedge clk);
    rd(12'h104); chk("R8 upper summary", rd_m, 32'h8000_0100);
    rd(12'h100); chk("R8 lower summary", rd_m, 32'h0);
  endtask

  task automatic t_ext;
    wr(12'h050, 32'h0000_0001);
    wr(12'h030, 32'hFF00_0000);
    @(negedge clk); irq_in[160] = 1'b1; irq_in[120] = 1'b1;
    @(negedge clk);
    chk("R11 full variant group 20", 64'(out_m[20]), 1);
    chk("R11 reduced ignores group 20", 64'(out_x_hi[4]), 0);
    chk("R11 reduced keeps group 15", 64'(out_x_lo[15]), 1);
    rd(12'h058);
    chk("R11 full raw group 20", rd_m, 32'h1);
    chk("R11 reduced raw group 20", rd_x, 32'h0);
    rd(12'h100);
    chk("R11 full summary", rd_m, 32'h0010_8000);
    chk("R11 reduced summary", rd_x, 32'h0000_8000);
    rd(12'h104); chk("R11 reduced upper summary", rd_x, 32'h0);
  endtask

  task automatic t_reset_mid;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R12 lines after mid reset", out_m, 64'h0);
    rd(12'h05C); chk("R12 enables cleared", rd_m, 32'h0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mapping();
    t_setclr();
    t_reject();
    t_reads();
    t_summary();
    t_ext();
    t_reset_mid();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule